// File: doc/BRIEF.md
# Parallel Pixel Point-Operation Unit

This block accepts a stream of RGB pixels, one per accepted clock, and computes six independent point enhancements on each pixel in parallel hardware lanes: brightness raise, brightness lower, contrast stretch, contrast squeeze, negative, and binary threshold. A three-bit operation code chooses which lane's result leaves the block. Each output pixel depends only on the input pixel accepted with it. No neighbouring pixels are involved.

Runtime inputs set the brightness offset, a base contrast gain with a gain step, and the threshold level. The three colour channels are processed separately with the same operation and settings. The block has a fixed two-cycle latency. A typical use sits between a frame reader and a display path, for example on 640 by 480 frames. The operator can switch the operation code at any time, and the next accepted pixel uses the new operation.

Top module: `pix_point_unit`

## Requirements
- R1: `op_sel` is captured together with each accepted pixel and chooses the result: 0 brightness raise, 1 brightness lower, 2 contrast stretch, 3 contrast squeeze, 4 negative, 5 threshold. Codes 6 and 7 pass the pixel through unchanged.
- R2: Brightness raise outputs the channel plus `bright_ofs`, saturated at 255.
- R3: Brightness lower outputs the channel minus `bright_ofs`, floored at 0.
- R4: Contrast stretch uses the gain g = min(`con_gain` + `con_step`, 255), an unsigned value with 4 fractional bits. The output is clamp(128 + ((c − 128)·g >>> 4), 0, 255), where the shift is an arithmetic right shift that rounds toward minus infinity.
- R5: Contrast squeeze uses the same formula with g = max(`con_gain` − `con_step`, 0).
- R6: Negative outputs 255 minus the channel value.
- R7: Threshold outputs 255 when the channel is greater than or equal to `thr_level`, and 0 otherwise.
- R8: Red is `in_pix[23:16]`, green is `[15:8]` and blue is `[7:0]`, with the same positions on `out_pix`. Each channel is computed only from its own input channel.
- R9: A pixel accepted on clock edge k appears on `out_pix` with `out_valid` high after edge k+1. `out_valid` equals `in_valid` delayed by two cycles.
- R10: While `out_valid` is low, `out_pix` holds its last value. Changes on `op_sel` or on the settings while `in_valid` is low have no effect on the output.
- R11: While the synchronous active-high `rst` is asserted, `out_valid` and `out_pix` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 24 | Input RGB pixel |
| op_sel | input | 3 | Operation code |
| bright_ofs | input | 8 | Brightness offset |
| con_gain | input | 8 | Base contrast gain, 4 fractional bits |
| con_step | input | 8 | Contrast gain step, 4 fractional bits |
| thr_level | input | 8 | Threshold level |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 24 | Output RGB pixel |

## Verification
A lane with a wrong clamp or a wrong rounding shows up on the channel it affects. With the operation code set to that lane, the wrong value appears two cycles after the pixel is accepted. Mixed pixels such as 240/128/16 and 100/99/129 drive one channel into each clamp region and exercise the odd-halving rounding case. A select code registered in the wrong stage, or taken from the live input, makes back-to-back pixels with different codes come out with each other's operation. A valid path with a stage too many or too few moves `out_valid` one cycle, and the bench checks the cycles on both sides of the correct one.

// File: rtl/pxop_pkg.sv
package pxop_pkg;
  localparam int NLANE = 6;
  typedef enum logic [2:0] {
    OP_BRT_UP = 3'd0,
    OP_BRT_DN = 3'd1,
    OP_CON_UP = 3'd2,
    OP_CON_DN = 3'd3,
    OP_NEG    = 3'd4,
    OP_THR    = 3'd5
  } op_e;
endpackage

// File: rtl/pxop_gain_adj.sv
module pxop_gain_adj #(
  parameter int GW = 8
) (
  input  logic [GW-1:0] gain,
  input  logic [GW-1:0] step,
  output logic [GW-1:0] gain_up,
  output logic [GW-1:0] gain_dn
);
  logic [GW:0] up_sum;
  always_comb begin
    up_sum  = {1'b0, gain} + {1'b0, step};
    gain_up = up_sum[GW] ? {GW{1'b1}} : up_sum[GW-1:0];
    gain_dn = (gain >= step) ? (gain - step) : '0;
  end
endmodule

// File: rtl/pxop_chan_lanes.sv
module pxop_chan_lanes
  import pxop_pkg::*;
#(
  parameter int CW   = 8,
  parameter int GW   = 8,
  parameter int FRAC = 4
) (
  input  logic [CW-1:0]                x,
  input  logic [CW-1:0]                ofs,
  input  logic [GW-1:0]                g_up,
  input  logic [GW-1:0]                g_dn,
  input  logic [CW-1:0]                thr,
  output logic [NLANE-1:0][CW-1:0]     res
);
  localparam int PW   = CW + GW + 2;
  localparam int MID  = 1 << (CW - 1);
  localparam int MAXV = (1 << CW) - 1;
  localparam logic signed [PW-1:0] MID_S = PW'(MID);
  localparam logic signed [PW-1:0] MAX_S = PW'(MAXV);

  // distance from mid-gray, scaled and re-centred, then clamped
  function automatic logic [CW-1:0] scale(input logic [CW-1:0] c, input logic [GW-1:0] g);
    logic signed [PW-1:0] d, gs, prod, sum;
    d    = $signed({{(PW-CW){1'b0}}, c}) - MID_S;
    gs   = $signed({{(PW-GW){1'b0}}, g});
    prod = d * gs;
    sum  = (prod >>> FRAC) + MID_S;
    if (sum < 0)          scale = '0;
    else if (sum > MAX_S) scale = {CW{1'b1}};
    else                  scale = sum[CW-1:0];
  endfunction

  logic [CW:0] add_sum;
  always_comb begin
    add_sum        = {1'b0, x} + {1'b0, ofs};
    res[OP_BRT_UP] = add_sum[CW] ? {CW{1'b1}} : add_sum[CW-1:0];
    res[OP_BRT_DN] = (x >= ofs) ? (x - ofs) : '0;
    res[OP_CON_UP] = scale(x, g_up);
    res[OP_CON_DN] = scale(x, g_dn);
    res[OP_NEG]    = ~x;
    res[OP_THR]    = (x >= thr) ? {CW{1'b1}} : '0;
  end
endmodule

// File: rtl/pix_point_unit.sv
module pix_point_unit
  import pxop_pkg::*;
#(
  parameter int CW   = 8,
  parameter int NCH  = 3,
  parameter int GW   = 8,
  parameter int FRAC = 4,
  parameter int SW   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [NCH*CW-1:0] in_pix,
  input  logic [SW-1:0]     op_sel,
  input  logic [CW-1:0]     bright_ofs,
  input  logic [GW-1:0]     con_gain,
  input  logic [GW-1:0]     con_step,
  input  logic [CW-1:0]     thr_level,
  output logic              out_valid,
  output logic [NCH*CW-1:0] out_pix
);
  localparam int PXW = NCH * CW;

  logic [GW-1:0] g_up, g_dn;
  pxop_gain_adj #(.GW(GW)) u_gain (
    .gain(con_gain), .step(con_step), .gain_up(g_up), .gain_dn(g_dn)
  );

  logic [NLANE-1:0][CW-1:0] lane_c [NCH];
  logic [NLANE-1:0][CW-1:0] lane_q [NCH];
  logic [PXW-1:0] pix_q;
  logic [SW-1:0]  sel_q;
  logic           vld_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pxop_chan_lanes #(.CW(CW), .GW(GW), .FRAC(FRAC)) u_lanes (
      .x(in_pix[ch*CW +: CW]), .ofs(bright_ofs), .g_up(g_up), .g_dn(g_dn),
      .thr(thr_level), .res(lane_c[ch])
    );
    always_ff @(posedge clk) begin
      if (rst)           lane_q[ch] <= '0;
      else if (in_valid) lane_q[ch] <= lane_c[ch];
    end
  end

  // stage 1: lane results, operation code and raw pixel travel together
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      sel_q <= '0;
      pix_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        sel_q <= op_sel;
        pix_q <= in_pix;
      end
    end
  end

  // stage 2: lane selection into the output register
  logic [PXW-1:0] pick;
  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      if (sel_q < SW'(NLANE)) pick[ch*CW +: CW] = lane_q[ch][sel_q];
      else                    pick[ch*CW +: CW] = pix_q[ch*CW +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= vld_q;
      if (vld_q) out_pix <= pick;
    end
  end
endmodule

// File: rtl/pxop_checker.sv
module pxop_checker #(
  parameter int CW  = 8,
  parameter int NCH = 3,
  parameter int SW  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [NCH*CW-1:0] in_pix,
  input logic [SW-1:0]     op_sel,
  input logic              out_valid,
  input logic [NCH*CW-1:0] out_pix
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)           cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end
  wire warm = (cyc >= 2'd2);

  function automatic logic all_binary(input logic [NCH*CW-1:0] p);
    all_binary = 1'b1;
    for (int c = 0; c < NCH; c++)
      if (p[c*CW +: CW] != '0 && p[c*CW +: CW] != {CW{1'b1}}) all_binary = 1'b0;
  endfunction

  function automatic logic all_ge(input logic [NCH*CW-1:0] a, input logic [NCH*CW-1:0] b);
    all_ge = 1'b1;
    for (int c = 0; c < NCH; c++)
      if (a[c*CW +: CW] < b[c*CW +: CW]) all_ge = 1'b0;
  endfunction

  assert_valid_delay_R9: assert property (@(posedge clk) disable iff (rst)
    warm |-> (out_valid == $past(in_valid, 2)));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (warm && !out_valid) |-> $stable(out_pix));

  assert_negative_R6: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(in_valid, 2) && $past(op_sel, 2) == 3'd4) |-> (out_pix == ~$past(in_pix, 2)));

  assert_binary_thr_R7: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(in_valid, 2) && $past(op_sel, 2) == 3'd5) |-> all_binary(out_pix));

  assert_no_decrease_R2: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(in_valid, 2) && $past(op_sel, 2) == 3'd0) |-> all_ge(out_pix, $past(in_pix, 2)));

  assert_no_increase_R3: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(in_valid, 2) && $past(op_sel, 2) == 3'd1) |-> all_ge($past(in_pix, 2), out_pix));

  assert_pass_codes_R1: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(in_valid, 2) && $past(op_sel, 2) >= 3'd6) |-> (out_pix == $past(in_pix, 2)));
endmodule

bind pix_point_unit pxop_checker #(.CW(CW), .NCH(NCH), .SW(SW)) u_pxop_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix), .op_sel(op_sel),
  .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/test_pix_point_unit.sv
module test_pix_point_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] in_pix = '0;
  logic [2:0]  op_sel = '0;
  logic [7:0]  bright_ofs = '0, con_gain = '0, con_step = '0, thr_level = '0;
  logic        out_valid;
  logic [23:0] out_pix;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_point_unit i_pix_point_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix), .op_sel(op_sel),
    .bright_ofs(bright_ofs), .con_gain(con_gain), .con_step(con_step),
    .thr_level(thr_level), .out_valid(out_valid), .out_pix(out_pix)
  );

  // {req, sel, pix, ofs, gain, step, thr, expected}
  localparam logic [86:0] VEC [NV] = '{
    {4'd2,  3'd0, 24'hF08010, 8'd40,  8'h18, 8'h08, 8'd100, 24'hFFA838}, // R2 clamp on red
    {4'd3,  3'd1, 24'hF08010, 8'd40,  8'h18, 8'h08, 8'd100, 24'hC85800}, // R3 floor on blue
    {4'd4,  3'd2, 24'hF08010, 8'd40,  8'h18, 8'h08, 8'd100, 24'hFF8000}, // R4 gain 2.0
    {4'd5,  3'd3, 24'hF08010, 8'd40,  8'h18, 8'h08, 8'd100, 24'hF08010}, // R5 gain 1.0
    {4'd6,  3'd4, 24'hF08010, 8'd40,  8'h18, 8'h08, 8'd100, 24'h0F7FEF}, // R6
    {4'd7,  3'd5, 24'hF08010, 8'd40,  8'h18, 8'h08, 8'd100, 24'hFFFF00}, // R7
    {4'd1,  3'd6, 24'hF08010, 8'd40,  8'h18, 8'h08, 8'd100, 24'hF08010}, // R1 pass code 6
    {4'd4,  3'd2, 24'h646381, 8'd0,   8'h14, 8'h04, 8'd100, 24'h565481}, // R4 floor rounding
    {4'd7,  3'd5, 24'h646381, 8'd0,   8'h14, 8'h04, 8'd100, 24'hFF00FF}, // R7 equal -> 255
    {4'd2,  3'd0, 24'h646381, 8'd0,   8'h14, 8'h04, 8'd100, 24'h646381}, // R2 zero offset
    {4'd5,  3'd3, 24'h646381, 8'd0,   8'h04, 8'h08, 8'd100, 24'h808080}, // R5 gain floors at 0
    {4'd4,  3'd2, 24'h646381, 8'd0,   8'hFC, 8'h10, 8'd100, 24'h00008F}, // R4 gain saturates
    {4'd3,  3'd1, 24'hF08010, 8'hFF,  8'h10, 8'h00, 8'd0,   24'h000000}, // R3 full offset
    {4'd2,  3'd0, 24'h646381, 8'hFF,  8'h10, 8'h00, 8'd0,   24'hFFFFFF}, // R2 full offset
    {4'd7,  3'd5, 24'h646381, 8'd0,   8'h10, 8'h00, 8'd0,   24'hFFFFFF}, // R7 level 0
    {4'd8,  3'd5, 24'hFF00FE, 8'd0,   8'h10, 8'h00, 8'hFF,  24'hFF0000}, // R8 channels apart
    {4'd1,  3'd7, 24'h646381, 8'd0,   8'h10, 8'h00, 8'd0,   24'h646381}  // R1 pass code 7
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] s, input logic [23:0] p, input logic [7:0] o,
                       input logic [7:0] g, input logic [7:0] st, input logic [7:0] t);
    op_sel = s; in_pix = p; bright_ofs = o; con_gain = g; con_step = st; thr_level = t;
    in_valid = 1'b1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R11 out_valid", {23'd0, out_valid}, 24'd0);
    check("R11 out_pix", out_pix, 24'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][82:80], VEC[i][79:56], VEC[i][55:48], VEC[i][47:40], VEC[i][39:32], VEC[i][31:24]);
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 early valid", {23'd0, out_valid}, 24'd0);
      @(negedge clk);
      check("R9 valid", {23'd0, out_valid}, 24'd1);
      check($sformatf("R%0d vector %0d", VEC[i][86:83], i), out_pix, VEC[i][23:0]);
      @(negedge clk);
      check("R9 valid drop", {23'd0, out_valid}, 24'd0);
    end

    // R10: settings and code wiggled while idle leave the output alone
    op_sel = 3'd4; in_pix = 24'h123456; bright_ofs = 8'h55;
    repeat (3) @(negedge clk);
    check("R10 hold", out_pix, 24'h646381);

    // R1: back-to-back pixels keep their own codes
    drive(3'd4, 24'h00FF10, 8'd0, 8'h10, 8'h00, 8'd0);
    @(negedge clk);
    drive(3'd1, 24'h205010, 8'h20, 8'h10, 8'h00, 8'd0);
    @(negedge clk);
    in_valid = 1'b0;
    op_sel = 3'd5;
    check("R1 first of pair", out_pix, 24'hFF00EF);
    @(negedge clk);
    check("R1 second of pair", out_pix, 24'h003000);
    check("R9 pair valid", {23'd0, out_valid}, 24'd1);

    // R11: reset mid-stream clears the output
    drive(3'd6, 24'hABCDEF, 8'd0, 8'h10, 8'h00, 8'd0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset valid", {23'd0, out_valid}, 24'd0);
    check("R11 reset pix", out_pix, 24'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule